// File: doc/BRIEF.md
# Binary Mismatch-Count Dot-Product Engine

This block computes the inner product of two binarised vectors, as used in the convolution step of a binary neural network. Each operand element is a ±1 value stored as a single bit. The block holds up to sixteen 32-bit words in parallel lanes. For each word position it reads one activation word and one weight word and stores their XOR in a lane. A set bit in that XOR marks a position where the signs differ. Each lane then counts its set bits bit-serially. On every one of 32 rounds, all lanes add their lowest bit to a private counter and shift right by one. A final serial pass adds the lane counters one at a time into the scalar mismatch count.

A controller starts a job with a one-cycle start strobe and a word count. During the load phase the block drives a word address. The surrounding memory returns both operand words combinationally on the same cycle. When the job finishes, the block raises done for one cycle. It then holds two results until its next job ends: the mismatch count S, and the signed ±1 dot product 32·N − 2·S.

Top module: `bnn_mismatch_engine`

## Requirements
- R1: After synchronous reset, busy and done are low, and mismatch and dot are both zero.
- R2: mismatch equals the total number of bit positions in which act_rdata and wgt_rdata differ, summed over addresses 0 to N−1.
- R3: A word_count from 1 to 16 sets N directly. A word_count of 0 or above 16 is treated as N = 16.
- R4: Operand words at addresses N and above have no effect on mismatch or dot.
- R5: Lane shifts are logical, so zeros enter at bit 31. A word pair differing only in bit 31 adds exactly 1 to the count.
- R6: done is high exactly 2·N + 32 clock cycles after the rising edge at which start is accepted.
- R7: done is high for exactly one cycle. busy is high from the cycle after acceptance until done, and is low while done is high.
- R8: start is ignored while busy is high. A job's result and its latency are unaffected by a start pulse during the job, and no new job begins afterwards.
- R9: mismatch and dot change only on the edge that raises done. They stay stable after done until a later job completes, even if the operand memory changes.
- R10: dot is the 11-bit two's complement value of 32·N − 2·mismatch, using the effective N of the job that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, sampled while idle |
| word_count | input | 5 | Number of 32-bit words N (0 or above 16 means 16) |
| rd_addr | output | 4 | Word address presented to the operand memory |
| act_rdata | input | 32 | Activation word at rd_addr, same cycle |
| wgt_rdata | input | 32 | Weight word at rd_addr, same cycle |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 10 | Count S of differing bit positions |
| dot | output | 11 | Signed ±1 dot product 32·N − 2·S |

## Verification
The count is exercised with pseudo-random operand pairs, which separate a correct per-bit popcount from lane mix-ups. Identical and fully inverted pairs pin the two extremes, 0 and 32·N. Alternating-bit pairs give exactly 16 per word, which exposes a counter that skips rounds. A pair differing only in the top bit must give 1 per word, so an arithmetic shift (which would replicate that bit) is caught. Every run fills the words beyond N with maximal mismatches, so reading past the requested length shows up in the result. Directed runs cover word counts of 1, 16, 0 and 20, a start pulse in mid-job, and memory rewrites after completion.

// File: rtl/bme_pkg.sv
package bme_pkg;

    localparam int LANES   = 16;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(LANES);
    localparam int NCNT_W  = $clog2(LANES + 1);
    localparam int RND_W   = $clog2(WORD_W);
    localparam int LCNT_W  = $clog2(WORD_W + 1);
    localparam int SUM_W   = $clog2(LANES * WORD_W + 1);
    localparam int DOT_W   = SUM_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_SHIFT = 2'd2,
        PH_SUM   = 2'd3
    } phase_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic shift;
        logic acc;
        logic last;
    } step_s;

    function automatic logic [NCNT_W-1:0] clamp_count(input logic [NCNT_W-1:0] req);
        if (req == '0 || req > NCNT_W'(LANES))
            return NCNT_W'(LANES);
        return req;
    endfunction

endpackage

// File: rtl/bme_lane.sv
module bme_lane
    import bme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    output logic [LCNT_W-1:0] cnt
);

    logic [WORD_W-1:0] word_q;
    logic [LCNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (load_en) begin
            word_q <= load_word;
            cnt_q  <= '0;
        end else if (shift_en) begin
            cnt_q  <= cnt_q + LCNT_W'(word_q[0]);
            word_q <= {1'b0, word_q[WORD_W-1:1]};
        end
    end

    assign cnt = cnt_q;

    // R5: a shift always leaves a zero in the top bit
    assert_logical_shift_R5: assert property (@(posedge clk) disable iff (rst)
        shift_en && !clear && !load_en |=> !word_q[WORD_W-1]);

    // R2: a lane never counts more bits than one word holds
    assert_lane_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LCNT_W'(WORD_W));

endmodule

// File: rtl/bme_ctrl.sv
module bme_ctrl
    import bme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NCNT_W-1:0] word_count,
    output step_s             step,
    output logic [IDX_W-1:0]  idx,
    output logic [NCNT_W-1:0] n_eff,
    output logic              busy,
    output logic              done
);

    phase_e             phase_q;
    logic [IDX_W-1:0]   idx_q;
    logic [RND_W-1:0]   round_q;
    logic [NCNT_W-1:0]  n_q;
    logic               done_q;
    logic               at_last;

    assign at_last = ({1'b0, idx_q} == (n_q - NCNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            round_q <= '0;
            n_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        n_q     <= clamp_count(word_count);
                        idx_q   <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (at_last) begin
                        idx_q   <= '0;
                        round_q <= '0;
                        phase_q <= PH_SHIFT;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_SHIFT: begin
                    round_q <= round_q + RND_W'(1);
                    if (round_q == RND_W'(WORD_W - 1)) begin
                        idx_q   <= '0;
                        phase_q <= PH_SUM;
                    end
                end
                PH_SUM: begin
                    if (at_last) begin
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        step.clear = (phase_q == PH_IDLE) && start;
        step.load  = (phase_q == PH_LOAD);
        step.shift = (phase_q == PH_SHIFT);
        step.acc   = (phase_q == PH_SUM);
        step.last  = (phase_q == PH_SUM) && at_last;
    end

    assign idx   = idx_q;
    assign n_eff = n_q;
    assign busy  = (phase_q != PH_IDLE);
    assign done  = done_q;

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done coincides with the idle state
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: a start seen during a job leaves the job length untouched
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> n_q == $past(n_q));

    // R4: the read address never reaches past the job length
    assert_addr_range_R4: assert property (@(posedge clk) disable iff (rst)
        busy && phase_q == PH_LOAD |-> {1'b0, idx_q} < n_q);

    // R3: an accepted job length is within 1..LANES
    assert_len_range_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (n_q != '0) && (n_q <= NCNT_W'(LANES)));

endmodule

// File: rtl/bme_reduce.sv
module bme_reduce
    import bme_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  step_s                    step,
    input  logic [LCNT_W-1:0]        cnt_sel,
    input  logic [NCNT_W-1:0]        n_eff,
    output logic [SUM_W-1:0]         result,
    output logic signed [DOT_W-1:0]  dot
);

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] result_q;
    logic [DOT_W-1:0] dot_q;
    logic [SUM_W-1:0] sum_next;
    logic [DOT_W-1:0] dot_next;

    assign sum_next = acc_q + SUM_W'(cnt_sel);
    assign dot_next = DOT_W'(n_eff) * DOT_W'(WORD_W) - (DOT_W'(sum_next) << 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            result_q <= '0;
            dot_q    <= '0;
        end else if (step.clear) begin
            acc_q <= '0;
        end else if (step.acc) begin
            if (step.last) begin
                result_q <= sum_next;
                dot_q    <= dot_next;
                acc_q    <= '0;
            end else begin
                acc_q <= sum_next;
            end
        end
    end

    assign result = result_q;
    assign dot    = $signed(dot_q);

    // R9: outputs only move on the completing step
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !step.last |=> $stable(result_q) && $stable(dot_q));

    // R2: the total never exceeds the lane capacity
    assert_sum_bound_R2: assert property (@(posedge clk) disable iff (rst)
        result_q <= SUM_W'(LANES * WORD_W));

endmodule

// File: rtl/bnn_mismatch_engine.sv
module bnn_mismatch_engine
    import bme_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [NCNT_W-1:0]        word_count,
    output logic [IDX_W-1:0]         rd_addr,
    input  logic [WORD_W-1:0]        act_rdata,
    input  logic [WORD_W-1:0]        wgt_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [SUM_W-1:0]         mismatch,
    output logic signed [DOT_W-1:0]  dot
);

    step_s             step;
    logic [IDX_W-1:0]  idx;
    logic [NCNT_W-1:0] n_eff;
    logic [LCNT_W-1:0] lane_cnt [LANES];
    logic [LCNT_W-1:0] cnt_sel;
    logic [WORD_W-1:0] xor_word;

    assign xor_word = act_rdata ^ wgt_rdata;
    assign rd_addr  = idx;

    bme_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .step       (step),
        .idx        (idx),
        .n_eff      (n_eff),
        .busy       (busy),
        .done       (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bme_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .clear     (step.clear),
            .load_en   (step.load && (idx == IDX_W'(g))),
            .load_word (xor_word),
            .shift_en  (step.shift),
            .cnt       (lane_cnt[g])
        );
    end

    assign cnt_sel = lane_cnt[idx];

    bme_reduce u_reduce (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .cnt_sel (cnt_sel),
        .n_eff   (n_eff),
        .result  (mismatch),
        .dot     (dot)
    );

endmodule

// File: tb/bnn_mismatch_engine_tb.sv
module bnn_mismatch_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [4:0]  n;
        logic [2:0]  kind;
        logic [31:0] seed;
    } vec_t;

    // kind: 0 random pair, 1 identical, 2 inverted, 3 alternating vs zero,
    //       4 top bit only vs zero, 5 all ones vs zero
    localparam vec_t VECS [NV] = '{
        '{n: 5'd1,  kind: 3'd0, seed: 32'h1234_5678},
        '{n: 5'd7,  kind: 3'd0, seed: 32'hCAFE_0001},
        '{n: 5'd16, kind: 3'd0, seed: 32'h0BAD_F00D},
        '{n: 5'd5,  kind: 3'd1, seed: 32'h0000_0042},
        '{n: 5'd16, kind: 3'd2, seed: 32'h7777_1111},
        '{n: 5'd9,  kind: 3'd3, seed: 32'h0000_0003},
        '{n: 5'd12, kind: 3'd4, seed: 32'h0000_0009},
        '{n: 5'd3,  kind: 3'd5, seed: 32'h0000_0011}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  word_count = 5'd0;
    logic [3:0]  rd_addr;
    logic [31:0] act_rdata, wgt_rdata;
    logic        busy, done;
    logic [9:0]  mismatch;
    logic signed [10:0] dot;

    logic [31:0] act_mem [16];
    logic [31:0] wgt_mem [16];

    int n_checks = 0;
    int n_fail   = 0;
    int exp_s;
    int exp_dot;
    int lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign act_rdata = act_mem[rd_addr];
    assign wgt_rdata = wgt_mem[rd_addr];

    bnn_mismatch_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .rd_addr    (rd_addr),
        .act_rdata  (act_rdata),
        .wgt_rdata  (wgt_rdata),
        .busy       (busy),
        .done       (done),
        .mismatch   (mismatch),
        .dot        (dot)
    );

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x >> 16);
        y = y * 32'h7FEB_352D;
        y = y ^ (y >> 15);
        y = y * 32'h846C_A68B;
        return y ^ (y >> 16);
    endfunction

    function automatic int eff_n(input logic [4:0] req);
        if (req == 5'd0 || req > 5'd16) return 16;
        return int'(req);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Fill memory; words at index >= effective N are maximal mismatches (R4)
    task automatic fill(input logic [2:0] kind, input logic [31:0] seed, input logic [4:0] req);
        int ne;
        ne = eff_n(req);
        exp_s = 0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a, w;
            a = mix(seed + 32'(i));
            case (kind)
                3'd0: w = mix(seed ^ (32'(i) * 32'h9E37_79B9) ^ 32'h5555_0000);
                3'd1: w = a;
                3'd2: w = ~a;
                3'd3: begin a = 32'hAAAA_AAAA; w = 32'h0; end
                3'd4: begin a = 32'h8000_0000; w = 32'h0; end
                default: begin a = 32'hFFFF_FFFF; w = 32'h0; end
            endcase
            if (i >= ne) begin
                a = mix(seed ^ 32'(i + 100));
                w = ~a;
            end
            act_mem[i] = a;
            wgt_mem[i] = w;
            if (i < ne) exp_s += $countones(a ^ w);
        end
        exp_dot = 32 * ne - 2 * exp_s;
    endtask

    // Launch a job and count cycles until done; optional mid-job start pulse
    task automatic run(input logic [4:0] req, input bit poke);
        @(negedge clk);
        word_count = req;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 10) begin
                start = 1'b1;
                word_count = 5'd16;
            end
            if (poke && lat == 11) start = 1'b0;
            if (!done && lat >= 1) begin
                n_checks++;
                if (!busy) begin
                    n_fail++;
                    $display("FAIL R7: busy actual 0 expected 1 at cycle %0d", lat);
                end
            end
        end
    endtask

    task automatic run_and_check(input logic [4:0] req, input string tag, input bit poke);
        run(req, poke);
        check({tag, " R6 latency"}, lat, 2 * eff_n(req) + 32);
        check({tag, " R2 mismatch"}, int'(mismatch), exp_s);
        check({tag, " R10 dot"}, int'(dot), exp_dot);
        check({tag, " R7 busy low at done"}, int'(busy), 0);
        @(negedge clk);
        check({tag, " R7 done width"}, int'(done), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            act_mem[i] = '0;
            wgt_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 mismatch", int'(mismatch), 0);
        check("R1 dot", int'(dot), 0);

        // Table walk: R2, R4, R5 (kind 4), R6, R10
        for (int v = 0; v < NV; v++) begin
            fill(VECS[v].kind, VECS[v].seed, VECS[v].n);
            run_and_check(VECS[v].n, $sformatf("vec%0d", v), 1'b0);
        end

        // R5: top-bit-only pairs count one per word
        fill(3'd4, 32'h0, 5'd4);
        run_and_check(5'd4, "R5 msb", 1'b0);
        check("R5 msb count", int'(mismatch), 4);

        // R3: zero and oversized counts mean sixteen words
        fill(3'd0, 32'hFEED_BEEF, 5'd0);
        run_and_check(5'd0, "R3 zero", 1'b0);
        fill(3'd5, 32'h0, 5'd20);
        run_and_check(5'd20, "R3 over", 1'b0);
        check("R3 over count", int'(mismatch), 512);
        check("R3 over dot", int'(dot), -512);

        // R8: start during a job is ignored
        fill(3'd0, 32'h0A0A_5050, 5'd3);
        run_and_check(5'd3, "R8 poke", 1'b1);
        repeat (3) @(negedge clk);
        check("R8 no new job", int'(busy), 0);

        // R9: outputs hold after done while memory changes
        begin
            int held_s, held_d;
            held_s = int'(mismatch);
            held_d = int'(dot);
            for (int i = 0; i < 16; i++) begin
                act_mem[i] = ~act_mem[i];
                wgt_mem[i] = 32'h0;
            end
            repeat (8) @(negedge clk);
            check("R9 hold mismatch", int'(mismatch), held_s);
            check("R9 hold dot", int'(dot), held_d);
            // R4: memory words past N ignored; identical-after-N run
            fill(3'd1, 32'h0000_7001, 5'd2);
            run_and_check(5'd2, "R4 tail", 1'b0);
            check("R4 tail zero", int'(mismatch), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R6: watchdog expired, actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule